// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the combinational execute-stage ALU of a small load/store integer core. It takes two operand words, a shift distance and a 4-bit operation code, and returns one result word together with a flag that is high when that word is all zeros. There are no registers inside it. Every output follows its inputs within the same cycle.

The operation set covers the following:
- wrapping addition and subtraction;
- three bitwise functions (AND, OR, NOR), where NOR against zero serves as the complement;
- a signed compare that yields 0 or 1;
- left and right logical shifts of operand B;
- placement of a half-word constant into the upper half of the result.

The choice between a register and an immediate for operand B is made upstream. Branch logic tests equality by issuing a subtraction and reading the zero flag.

Top module: `int_alu`

## Requirements
- R1: With op code 0 (add) the result is (A + B) modulo 2^32, with no overflow indication.
- R2: With op code 1 (subtract) the result is (A - B) modulo 2^32.
- R3: Op codes 2, 3 and 4 give A AND B, A OR B and NOT (A OR B) bit by bit; NOR with B = 0 yields the complement of A.
- R4: With op code 5 (set-less-than) the result is 1 when A is less than B as signed two's-complement numbers and 0 otherwise, and bits 31..1 are always zero.
- R5: With op code 6 the result is B shifted left by shamt (0 to 31) places with zeros entering at bit 0, which equals B times 2^shamt modulo 2^32.
- R6: With op code 7 the result is B shifted right by shamt places with zeros entering at bit 31.
- R7: With op code 8 the result holds B[15:0] in bits 31..16 and zeros in bits 15..0; A has no effect.
- R8: The zero output is 1 exactly when all 32 result bits are 0; under op code 1 it is therefore 1 exactly when A equals B.
- R9: Op codes 9 to 15 are unused; they give a result of 0 and a zero output of 1.
- R10: The shamt input has no effect on any operation other than op codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B, also the shift source and the constant source |
| shamt | input | 5 | Shift distance for op codes 6 and 7 |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Two of the block's functions can be active in the same cycle. One is the arithmetic or compare result. The other is the zero flag, which branch logic reads in that same cycle. The bench provokes both together in three ways. It subtracts equal operands, including 0x80000000 from itself. It adds values whose sum wraps exactly to zero. It issues set-less-than with operands that make the result 0. For every one of these steps the scoreboard judges the result word and the flag as separate checks against the reference model, so that a correct word with a stale flag, or the reverse, is still reported.

// File: rtl/int_alu_pkg.sv
// Package: shared operation codes for the integer ALU.
// Assumes a 4-bit code space; codes above OP_LUI are left unused.
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_NOR = 4'd4,
        OP_SLT = 4'd5,
        OP_SLL = 4'd6,
        OP_SRL = 4'd7,
        OP_LUI = 4'd8
    } alu_op_e;

    // Selects for the bitwise unit
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOR = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/int_alu_addsub.sv
// Module: shared adder/subtractor with a signed less-than output.
// Assumes two's-complement operands; the carry out is discarded (wrapping).
// lt_signed is only meaningful while sub_en is high.
module int_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         lt_signed
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         ovf;

    // Invert B and inject a carry for subtraction
    always_comb begin
        b_eff = b ^ {W{sub_en}};
        sum   = a + b_eff + {{(W-1){1'b0}}, sub_en};
    end

    // Signed compare: sign of the difference corrected by overflow
    always_comb begin
        ovf       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_signed = sum[MSB] ^ ovf;
    end

endmodule

// File: rtl/int_alu_logic.sv
// Module: bitwise AND / OR / NOR unit.
// Assumes the select is one of the three defined codes; others yield zero.
module int_alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]                  a,
    input  logic [W-1:0]                  b,
    input  int_alu_pkg::logic_sel_e       sel,
    output logic [W-1:0]                  y
);
    import int_alu_pkg::*;

    // Pick the bitwise function
    always_comb begin
        case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/int_alu_shift.sv
// Module: logarithmic logical shifter serving both directions.
// A right shift is done by reversing the word, shifting left, and
// reversing back, so only one stage chain exists. Zeros always fill.
// Assumes W is a power of two so that SW bits cover every distance.
module int_alu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          go_left,
    output logic [W-1:0]  dout
);
    logic [W-1:0] din_rev;
    logic [W-1:0] chain_out_rev;
    logic [W-1:0] stage [0:SW];

    // Bit reversal on the way in and the way out
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i]       = din[W-1-i];
        assign chain_out_rev[i] = stage[SW][W-1-i];
    end

    // Feed the chain with the word in the right orientation
    always_comb stage[0] = go_left ? din : din_rev;

    // One stage per shift-amount bit, each moving by 2^k
    for (genvar k = 0; k < SW; k++) begin : g_stage
        always_comb stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    // Undo the reversal for right shifts
    always_comb dout = go_left ? stage[SW] : chain_out_rev;

endmodule

// File: rtl/int_alu.sv
// Module: top of the integer ALU. Routes operands to the add/sub,
// bitwise and shift units, selects the result by op code and derives
// the zero flag. Purely combinational; no reset or clock is used.
// Assumes operand muxing (register or immediate) is done upstream.
module int_alu #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic [SW-1:0] shamt,
    input  logic [3:0]    op,
    output logic [W-1:0]  result,
    output logic          zero
);
    import int_alu_pkg::*;

    localparam int HW = W / 2;

    alu_op_e      op_e;
    logic         sub_en;
    logic [W-1:0] as_sum;
    logic         as_lt;
    logic_sel_e   lg_sel;
    logic [W-1:0] lg_y;
    logic         sh_left;
    logic [W-1:0] sh_y;
    logic [W-1:0] lui_y;

    // Decode the op code into unit controls
    always_comb begin
        op_e    = alu_op_e'(op);
        sub_en  = (op_e == OP_SUB) || (op_e == OP_SLT);
        sh_left = (op_e == OP_SLL);
        case (op_e)
            OP_OR:   lg_sel = LG_OR;
            OP_NOR:  lg_sel = LG_NOR;
            default: lg_sel = LG_AND;
        endcase
    end

    int_alu_addsub #(.W(W)) u_addsub (
        .a         (a_in),
        .b         (b_in),
        .sub_en    (sub_en),
        .sum       (as_sum),
        .lt_signed (as_lt)
    );

    int_alu_logic #(.W(W)) u_logic (
        .a   (a_in),
        .b   (b_in),
        .sel (lg_sel),
        .y   (lg_y)
    );

    int_alu_shift #(.W(W), .SW(SW)) u_shift (
        .din     (b_in),
        .amt     (shamt),
        .go_left (sh_left),
        .dout    (sh_y)
    );

    // Upper-half constant placement
    always_comb lui_y = {b_in[HW-1:0], {HW{1'b0}}};

    // Result select by operation
    always_comb begin
        case (op_e)
            OP_ADD, OP_SUB:         result = as_sum;
            OP_AND, OP_OR, OP_NOR:  result = lg_y;
            OP_SLT:                 result = {{(W-1){1'b0}}, as_lt};
            OP_SLL, OP_SRL:         result = sh_y;
            OP_LUI:                 result = lui_y;
            default:                result = '0;
        endcase
    end

    // Zero detect over the full result word
    always_comb zero = ~|result;

endmodule

// Checker: property checks on the ALU ports, relating the outputs to
// the inputs through facts that hold independently of the datapath.
module int_alu_chk #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input logic [W-1:0]  a_in,
    input logic [W-1:0]  b_in,
    input logic [SW-1:0] shamt,
    input logic [3:0]    op,
    input logic [W-1:0]  result,
    input logic          zero
);
    localparam int HW = W / 2;

    // Immediate checks evaluated whenever the ports settle
    always_comb begin
        assert_sub_eq_R8: assert (op != 4'd1 || (zero == (a_in == b_in)))
            else $error("subtract zero flag disagrees with operand equality");
        assert_slt_bit_R4: assert (op != 4'd5 || result[W-1:1] == '0)
            else $error("set-less-than upper bits not zero");
        assert_and_sub_R3: assert (op != 4'd2 || ((result & ~(a_in & b_in)) == '0))
            else $error("AND result has bits outside both operands");
        assert_nor_R3: assert (op != 4'd4 || ((result & (a_in | b_in)) == '0))
            else $error("NOR result overlaps an operand bit");
        assert_sll_fill_R5: assert (op != 4'd6 || shamt == '0 || !result[0])
            else $error("left shift did not fill bit 0 with zero");
        assert_srl_fill_R6: assert (op != 4'd7 || shamt == '0 || !result[W-1])
            else $error("right shift did not fill the top bit with zero");
        assert_lui_low_R7: assert (op != 4'd8 || result[HW-1:0] == '0)
            else $error("upper placement left low half non-zero");
        assert_unused_R9: assert (op < 4'd9 || (result == '0 && zero))
            else $error("unused op code produced a value");
    end

endmodule

bind int_alu int_alu_chk #(.W(W), .SW(SW)) u_chk (
    .a_in   (a_in),
    .b_in   (b_in),
    .shamt  (shamt),
    .op     (op),
    .result (result),
    .zero   (zero)
);

// File: tb/sim_int_alu.sv
// Scoreboard bench: the driver applies stimulus on the rising edge and
// queues the expected word and flag; the monitor compares on the falling edge.
module sim_int_alu;

    localparam int W  = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic [SW-1:0] shamt = '0;
    logic [3:0]    op = '0;
    logic [W-1:0]  result;
    logic          zero;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         zf;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    int_alu #(.W(W), .SW(SW)) u0 (
        .a_in   (a_in),
        .b_in   (b_in),
        .shamt  (shamt),
        .op     (op),
        .result (result),
        .zero   (zero)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    // Reference model written from the requirements
    function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [SW-1:0] s);
        case (o)
            4'd0: return a + b;                                      // R1
            4'd1: return a - b;                                      // R2
            4'd2: return a & b;                                      // R3
            4'd3: return a | b;                                      // R3
            4'd4: return ~(a | b);                                   // R3
            4'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;  // R4
            4'd6: return b << s;                                     // R5
            4'd7: return b >> s;                                     // R6
            4'd8: return {b[15:0], 16'h0000};                        // R7
            default: return '0;                                      // R9
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Driver: apply one operation and queue its expectation
    task automatic drive(input logic [3:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [SW-1:0] s, input string tg);
        exp_t e;
        @(posedge clk);
        op = o; a_in = a; b_in = b; shamt = s;
        e.res = model(o, a, b, s);
        e.zf  = (e.res == '0);
        e.tag = tg;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs half a cycle after each drive
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (result !== e.res) begin
                n_errors++;
                $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h",
                         e.tag, op, a_in, b_in, shamt, result, e.res);
            end
            n_checks++;
            if (zero !== e.zf) begin
                n_errors++;
                $display("FAIL R8 (%s) op=%0d a=%h b=%h zero actual=%0b expected=%0b",
                         e.tag, op, a_in, b_in, zero, e.zf);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_errors++;
            $display("FAIL watchdog expired actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    logic [W-1:0] corners [0:5];

    initial begin
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF;
        corners[3] = 32'h8000_0000;
        corners[4] = 32'h7FFF_FFFF;
        corners[5] = 32'hA5A5_5A5A;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // State after reset with idle inputs: add of zeros -> 0, flag set (R1, R8)
        drive(4'd0, '0, '0, '0, "R1 reset");

        // Every op over the corner pairs
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    drive(4'(o), corners[i], corners[j], 5'(i * 7 + j), tag_of(4'(o)));

        // Wrapping and zero-flag coincidences (R1, R2, R8)
        drive(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, '0, "R1 wrap to zero");
        drive(4'd0, 32'h8000_0000, 32'h8000_0000, '0, "R1 wrap msb");
        drive(4'd1, 32'h0000_0000, 32'h0000_0001, '0, "R2 borrow wrap");
        drive(4'd1, 32'h1234_5678, 32'h1234_5678, '0, "R8 equal compare");
        drive(4'd1, 32'h1234_5678, 32'h1234_5679, '0, "R8 unequal compare");
        // NOR with zero gives complement (R3)
        drive(4'd4, 32'h0F0F_3C3C, 32'h0, '0, "R3 nor as not");
        // Signed compare across sign boundary (R4)
        drive(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, '0, "R4 min<max");
        drive(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, '0, "R4 max<min");
        drive(4'd5, 32'hFFFF_FFFF, 32'h0000_0000, '0, "R4 -1<0");

        // Every shift distance for both directions (R5, R6)
        for (int s = 0; s < 32; s++) begin
            drive(4'd6, '0, 32'h8000_0001, 5'(s), "R5 sweep");
            drive(4'd7, '0, 32'h8000_0001, 5'(s), "R6 sweep");
        end

        // Upper placement ignores A (R7)
        drive(4'd8, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 5'd3, "R7 a ignored");
        drive(4'd8, 32'h0000_0000, 32'hDEAD_BEEF, 5'd3, "R7 a ignored");

        // shamt has no effect outside shifts (R10)
        for (int o = 0; o < 16; o++) begin
            if (o == 6 || o == 7) continue;
            drive(4'(o), 32'h1357_9BDF, 32'h0246_8ACE, 5'd0,  "R10 shamt 0");
            drive(4'(o), 32'h1357_9BDF, 32'h0246_8ACE, 5'd31, "R10 shamt 31");
        end

        // Random operands over all op codes
        for (int n = 0; n < 3000; n++)
            drive(4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom), "");

        // Drain the scoreboard
        @(posedge clk);
        while (sb_q.size() != 0) @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule